// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a 24-bit virtual address into a physical address through a two-step scheme: the top bits pick a segment, and each segment owns its own linear page table in memory. A small register file holds, for every segment, the physical word address where that segment's page table starts, how many entries the table holds, and which access types the segment allows. A request that passes both the length check and the access-type check causes exactly one page-table entry to be fetched over a simple read port. The frame number in that entry is joined to the untouched page offset to form the result.

Requests arrive on a valid/ready handshake and the block handles one at a time. Each request ends with a one-cycle result strobe that carries either the physical address or an error flag. Software, or a controller above the block, loads the segment registers through a separate write port. A segment that was never loaded has a length of zero, so it rejects every access.

Top module: `segpage_xlate`

## Requirements
- R1: The virtual address is read as segment number in bits 23:20, page number in bits 19:12 and page offset in bits 11:0.
- R2: After reset, req_ready is high, rsp_valid and mem_rd_en are low, and every segment has length 0, so any request is answered with an error.
- R3: A page number greater than or equal to the segment's length (cfg_bound, 9 bits) produces rsp_err=1, and no memory read is issued for that request.
- R4: The 2-bit permission field gives reads in bit 1 and writes in bit 0. A read (req_write=0) to a segment with bit 1 clear, or a write (req_write=1) to a segment with bit 0 clear, produces rsp_err=1 with no memory read.
- R5: An accepted request with no error issues exactly one single-cycle mem_rd_en. The address is the segment base plus page number times ENTRY_WORDS (1 by default), taken modulo 2^16.
- R6: On success, rsp_paddr is the 12-bit frame returned on mem_rd_data (one cycle after mem_rd_en) in bits 23:12, with the request's offset in bits 11:0.
- R7: req_ready is high only when the block is idle, and a request is taken when req_valid and req_ready are both high at a rising edge. rsp_valid is a single-cycle pulse that comes 1 cycle after the accepting edge for a rejected request and 2 cycles after it for a translated one.
- R8: When cfg_we is high at a rising edge, it loads base, length and permission into segment cfg_seg only. Requests accepted afterwards see the new values, and other segments keep theirs.
- R9: When rsp_err is 1, rsp_paddr is 0.
- R10: The length check is inclusive of the last entry: page = length-1 translates, and a length of 256 admits every page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_seg | input | 4 | Segment index to write |
| cfg_base | input | 16 | Page-table base word address |
| cfg_bound | input | 9 | Number of entries in the page table |
| cfg_perm | input | 2 | Permission: bit 1 read allowed, bit 0 write allowed |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_vaddr | input | 24 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_rd_en | output | 1 | Page-table read strobe |
| mem_rd_addr | output | 16 | Page-table entry word address |
| mem_rd_data | input | 12 | Frame number, valid one cycle after mem_rd_en |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_err | output | 1 | Translation rejected |
| rsp_paddr | output | 24 | Physical address, 0 on error |

## Verification
The bench first sends requests to an unloaded table and then to four segments set up with distinct bases, lengths and permission pairs. Pages just below and at the length tell a strict comparison from an inclusive one. Read-only, write-only, open and closed segments show whether each permission bit gates the right access type. After one segment is reprogrammed, requests to it and to an untouched segment show that a write reaches only its target. A back-to-back stream of mixed requests with a computed entry memory checks entry addresses, frame placement, offsets and response latency together, and any read that no request should have caused is flagged.

// File: rtl/segpage_pkg.sv
package segpage_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_READ  = 2'd2,
    ST_DONE  = 2'd3
  } xl_state_t;

  // permission field bit positions
  localparam int PERM_RD_BIT = 1;
  localparam int PERM_WR_BIT = 0;
  localparam int PERM_W      = 2;

endpackage

// File: rtl/segpage_rst_sync.sv
module segpage_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/segpage_segfile.sv
module segpage_segfile
  import segpage_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int BASE_W  = 16,
  parameter int BOUND_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEG_W-1:0]   wr_seg,
  input  logic [BASE_W-1:0]  wr_base,
  input  logic [BOUND_W-1:0] wr_bound,
  input  logic [PERM_W-1:0]  wr_perm,
  input  logic [SEG_W-1:0]   rd_seg,
  output logic [BASE_W-1:0]  rd_base,
  output logic [BOUND_W-1:0] rd_bound,
  output logic [PERM_W-1:0]  rd_perm
);

  localparam int NSEG = 1 << SEG_W;

  logic [BASE_W-1:0]  base_q  [NSEG];
  logic [BOUND_W-1:0] bound_q [NSEG];
  logic [PERM_W-1:0]  perm_q  [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic load_en;
    assign load_en = wr_en && (wr_seg == SEG_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        bound_q[g] <= '0;
        perm_q[g]  <= '0;
      end else if (load_en) begin
        base_q[g]  <= wr_base;
        bound_q[g] <= wr_bound;
        perm_q[g]  <= wr_perm;
      end
    end
  end

  assign rd_base  = base_q[rd_seg];
  assign rd_bound = bound_q[rd_seg];
  assign rd_perm  = perm_q[rd_seg];

endmodule

// File: rtl/segpage_check.sv
module segpage_check
  import segpage_pkg::*;
#(
  parameter int PAGE_W      = 8,
  parameter int BASE_W      = 16,
  parameter int BOUND_W     = 9,
  parameter int ENTRY_WORDS = 1
) (
  input  logic [PAGE_W-1:0]  page,
  input  logic               is_write,
  input  logic [BASE_W-1:0]  base,
  input  logic [BOUND_W-1:0] bound,
  input  logic [PERM_W-1:0]  perm,
  output logic               bound_ok,
  output logic               perm_ok,
  output logic [BASE_W-1:0]  pte_addr
);

  logic [BASE_W-1:0] page_scaled;

  always_comb begin
    bound_ok    = {1'b0, page} < bound;
    perm_ok     = is_write ? perm[PERM_WR_BIT] : perm[PERM_RD_BIT];
    page_scaled = BASE_W'(page) * BASE_W'(ENTRY_WORDS);
    pte_addr    = base + page_scaled;
  end

endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
  import segpage_pkg::*;
#(
  parameter int SEG_W       = 4,
  parameter int PAGE_W      = 8,
  parameter int OFF_W       = 12,
  parameter int PT_AW       = 16,
  parameter int FRAME_W     = 12,
  parameter int ENTRY_WORDS = 1,
  localparam int VA_W       = SEG_W + PAGE_W + OFF_W,
  localparam int PA_W       = FRAME_W + OFF_W,
  localparam int BOUND_W    = PAGE_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SEG_W-1:0]   cfg_seg,
  input  logic [PT_AW-1:0]   cfg_base,
  input  logic [BOUND_W-1:0] cfg_bound,
  input  logic [1:0]         cfg_perm,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  output logic               mem_rd_en,
  output logic [PT_AW-1:0]   mem_rd_addr,
  input  logic [FRAME_W-1:0] mem_rd_data,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [PA_W-1:0]    rsp_paddr
);

  localparam int OFF_LO  = 0;
  localparam int PAGE_LO = OFF_W;
  localparam int SEG_LO  = OFF_W + PAGE_W;

  logic rst_n_sync;

  segpage_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  xl_state_t state_q, state_d;
  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic [PA_W-1:0] paddr_q, paddr_d;
  logic            err_q, err_d;
  logic            va_en, res_en;

  logic [SEG_W-1:0]   cur_seg;
  logic [PAGE_W-1:0]  cur_page;
  logic [OFF_W-1:0]   cur_off;
  logic [PT_AW-1:0]   seg_base;
  logic [BOUND_W-1:0] seg_bound;
  logic [PERM_W-1:0]  seg_perm;
  logic               bound_ok, perm_ok, access_ok;
  logic [PT_AW-1:0]   pte_addr;

  assign cur_seg  = va_q[SEG_LO  +: SEG_W];
  assign cur_page = va_q[PAGE_LO +: PAGE_W];
  assign cur_off  = va_q[OFF_LO  +: OFF_W];

  segpage_segfile #(
    .SEG_W   (SEG_W),
    .BASE_W  (PT_AW),
    .BOUND_W (BOUND_W)
  ) segfile_i (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_en    (cfg_we),
    .wr_seg   (cfg_seg),
    .wr_base  (cfg_base),
    .wr_bound (cfg_bound),
    .wr_perm  (cfg_perm),
    .rd_seg   (cur_seg),
    .rd_base  (seg_base),
    .rd_bound (seg_bound),
    .rd_perm  (seg_perm)
  );

  segpage_check #(
    .PAGE_W      (PAGE_W),
    .BASE_W      (PT_AW),
    .BOUND_W     (BOUND_W),
    .ENTRY_WORDS (ENTRY_WORDS)
  ) check_i (
    .page     (cur_page),
    .is_write (wr_q),
    .base     (seg_base),
    .bound    (seg_bound),
    .perm     (seg_perm),
    .bound_ok (bound_ok),
    .perm_ok  (perm_ok),
    .pte_addr (pte_addr)
  );

  assign access_ok = bound_ok && perm_ok;

  // next-state and datapath selection
  always_comb begin
    state_d = state_q;
    va_en   = 1'b0;
    res_en  = 1'b0;
    paddr_d = paddr_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          va_en   = 1'b1;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (access_ok) begin
          state_d = ST_READ;
        end else begin
          res_en  = 1'b1;
          err_d   = 1'b1;
          paddr_d = '0;
          state_d = ST_DONE;
        end
      end
      ST_READ: begin
        res_en  = 1'b1;
        err_d   = 1'b0;
        paddr_d = {mem_rd_data, cur_off};
        state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      va_q <= '0;
      wr_q <= 1'b0;
    end else if (va_en) begin
      va_q <= req_vaddr;
      wr_q <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      paddr_q <= '0;
      err_q   <= 1'b0;
    end else if (res_en) begin
      paddr_q <= paddr_d;
      err_q   <= err_d;
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign mem_rd_en   = (state_q == ST_CHECK) && access_ok;
  assign mem_rd_addr = pte_addr;
  assign rsp_valid   = (state_q == ST_DONE);
  assign rsp_err     = err_q;
  assign rsp_paddr   = paddr_q;

endmodule

// File: rtl/segpage_xlate_chk.sv
module segpage_xlate_chk #(
  parameter int OFF_W = 12,
  parameter int PA_W  = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [OFF_W-1:0] req_off,
  input logic             mem_rd_en,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [PA_W-1:0]  rsp_paddr
);

  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (req_valid && req_ready) begin
      off_q <= req_off;
    end
  end

  AST_NO_READ_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !$past(mem_rd_en)); // R3

  AST_READ_BEFORE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> $past(mem_rd_en, 2)); // R5

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R5

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (rsp_paddr[OFF_W-1:0] == off_q)); // R6

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_rd_en)); // R7

  AST_NO_EARLY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !rsp_valid); // R7

  AST_ERR_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_paddr == '0)); // R9

endmodule

bind segpage_xlate segpage_xlate_chk #(
  .OFF_W (OFF_W),
  .PA_W  (PA_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_off   (req_vaddr[OFF_W-1:0]),
  .mem_rd_en (mem_rd_en),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_paddr (rsp_paddr)
);

// File: tb/segpage_xlate_tb_top.sv
module segpage_xlate_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_seg;
  logic [15:0] cfg_base;
  logic [8:0]  cfg_bound;
  logic [1:0]  cfg_perm;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_vaddr;
  logic        req_write;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [11:0] mem_rd_data;
  logic        rsp_valid;
  logic        rsp_err;
  logic [23:0] rsp_paddr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;
  bit mon_on   = 0;

  // bench-side model of the segment table
  logic [15:0] m_base  [16];
  logic [8:0]  m_bound [16];
  logic [1:0]  m_perm  [16];

  bit          exp_err_q [$];
  logic [23:0] exp_pa_q  [$];
  int          exp_acc_q [$];
  logic [15:0] exp_addr_q[$];

  segpage_xlate dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_seg     (cfg_seg),
    .cfg_base    (cfg_base),
    .cfg_bound   (cfg_bound),
    .cfg_perm    (cfg_perm),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .req_write   (req_write),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_paddr   (rsp_paddr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [11:0] pte_of(input logic [15:0] a);
    logic [15:0] t;
    t = (a * 16'd7) ^ 16'h0A5C;
    return t[11:0];
  endfunction

  // page-table memory with one cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= pte_of(mem_rd_addr);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic cfg_write(input logic [3:0] s, input logic [15:0] b, input logic [8:0] n, input logic [1:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = s; cfg_base = b; cfg_bound = n; cfg_perm = p;
    @(negedge clk);
    cfg_we = 1'b0;
    m_base[s] = b; m_bound[s] = n; m_perm[s] = p;
  endtask

  // driver: computes the expected result and hands it to the scoreboard
  task automatic issue(input logic [3:0] s, input logic [7:0] p, input logic [11:0] o, input bit w);
    bit          e;
    logic [15:0] a;
    e = ({1'b0, p} >= m_bound[s]) || (w ? !m_perm[s][0] : !m_perm[s][1]);
    a = m_base[s] + {8'h00, p};
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_vaddr = {s, p, o};
    req_write = w;
    req_valid = 1'b1;
    exp_err_q.push_back(e);
    exp_pa_q.push_back(e ? 24'h0 : {pte_of(a), o});
    exp_acc_q.push_back(cyc + 1);
    if (!e) exp_addr_q.push_back(a);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: response scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && rsp_valid) begin
        if (exp_err_q.size() == 0) begin
          chk(1'b0, "R7 unexpected response", 32'(rsp_paddr), 32'h0);
        end else begin
          bit          e;
          logic [23:0] pa;
          int          acc;
          e   = exp_err_q.pop_front();
          pa  = exp_pa_q.pop_front();
          acc = exp_acc_q.pop_front();
          chk(rsp_err == e, "R2/R3/R4/R10 rsp_err", 32'(rsp_err), 32'(e));
          chk(rsp_paddr == pa, "R1/R6/R9 rsp_paddr", 32'(rsp_paddr), 32'(pa));
          chk((cyc - acc) == (e ? 1 : 2), "R7 latency", 32'(cyc - acc), e ? 32'd1 : 32'd2);
        end
      end
    end
  end

  // monitor: page-table reads
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && mem_rd_en) begin
        if (exp_addr_q.size() == 0) begin
          chk(1'b0, "R3/R4 read without valid request", 32'(mem_rd_addr), 32'h0);
        end else begin
          logic [15:0] a;
          a = exp_addr_q.pop_front();
          chk(mem_rd_addr == a, "R5 entry address", 32'(mem_rd_addr), 32'(a));
        end
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R7 run did not complete actual=%0d expected<20000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_seg = '0; cfg_base = '0; cfg_bound = '0; cfg_perm = '0;
    req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
    for (int i = 0; i < 16; i++) begin
      m_base[i] = '0; m_bound[i] = '0; m_perm[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state
    chk(req_ready == 1'b1, "R2 req_ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R2 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk(mem_rd_en == 1'b0, "R2 mem_rd_en after reset", 32'(mem_rd_en), 32'd0);
    mon_on = 1'b1;

    // R2: unloaded table rejects
    issue(4'h0, 8'h00, 12'h123, 1'b0);
    issue(4'h7, 8'h3C, 12'hFFF, 1'b1);

    cfg_write(4'h0, 16'h0100, 9'd16,  2'b11);  // open, 16 entries
    cfg_write(4'h1, 16'h0000, 9'd0,   2'b00);  // closed
    cfg_write(4'h2, 16'h0800, 9'd256, 2'b10);  // read only, full length
    cfg_write(4'hF, 16'hFF00, 9'd1,   2'b01);  // write only, one entry

    // R1/R6/R10/R3 on segment 0
    issue(4'h0, 8'h00, 12'hABC, 1'b0);
    issue(4'h0, 8'h0F, 12'h001, 1'b1);   // last entry (R10)
    issue(4'h0, 8'h10, 12'h001, 1'b0);   // equal to length (R3)
    issue(4'h0, 8'hFF, 12'h777, 1'b0);   // far out (R3)
    // R4 permission cases
    issue(4'h1, 8'h00, 12'h000, 1'b0);
    issue(4'h2, 8'hFF, 12'h5A5, 1'b0);   // R10 full length
    issue(4'h2, 8'h01, 12'h5A5, 1'b1);   // write to read-only (R4)
    issue(4'hF, 8'h00, 12'h0F0, 1'b1);   // write-only, allowed
    issue(4'hF, 8'h00, 12'h0F0, 1'b0);   // read to write-only (R4)
    issue(4'hF, 8'h01, 12'h0F0, 1'b1);   // past length (R3)

    // R8: reprogram segment 0, others unchanged
    cfg_write(4'h0, 16'h4000, 9'd2, 2'b11);
    issue(4'h0, 8'h05, 12'h321, 1'b0);
    issue(4'h0, 8'h01, 12'h321, 1'b0);
    issue(4'h2, 8'h80, 12'h00E, 1'b0);
    issue(4'hF, 8'h00, 12'hEEE, 1'b1);

    // mixed back-to-back stream
    for (int i = 0; i < 40; i++) begin
      logic [3:0] s;
      logic [31:0] r;
      r = $urandom;
      case (r[1:0])
        2'd0: s = 4'h0;
        2'd1: s = 4'h2;
        2'd2: s = 4'hF;
        default: s = 4'h1;
      endcase
      issue(s, r[9:2], r[21:10], r[22]);
    end

    repeat (10) @(negedge clk);
    chk(exp_err_q.size() == 0, "R7 all responses received", 32'(exp_err_q.size()), 32'd0);
    chk(exp_addr_q.size() == 0, "R5 all reads issued", 32'(exp_addr_q.size()), 32'd0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule